// File: doc/BRIEF.md
# Display Rail Power-Up Sequencer

This controller brings up the supply rails of a display panel power system in a fixed order. A timing node is modelled as an up/down ramp: each up-ramp (a fast segment followed by a slow segment) ends at a peak, and each down-ramp returns to the floor. Six peaks are counted, and each ramp phase carries one rail event. The first two up/down pairs act as a self-test of the ramp and the reference. Temperature is qualified before the boost converter may start. After the last peak the rails are checked together.

Once the supply is good, the reference and logic-rail enables come on whether or not the enable pin is high. Ramping waits for the enable pin. Any fault drops every output except the reference enable. The fault stays latched until the enable pin goes low or the supply is lost. The analog comparators and regulators lie outside the block. Runtime supervision after the sequence completes belongs to another block.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While reset is asserted or `supplyOk` is low, every enable is low and both active-low gates are high. On the first clock edge that samples `supplyOk` high, `refEn` and `logicEn` rise, whatever the state of `enable`.
- R2: No ramp phase advances while `enable` is low. The first up-ramp begins on the edge that samples `enable` high, which is cycle 0. An up-ramp lasts at least FAST_CYC+SLOW_CYC cycles and ends only in a cycle with `rampHi` high. A down-ramp lasts at least DOWN_CYC cycles and ends only with `rampLo` high.
- R3: If `refOk` is low during any of the first four ramp phases, the block enters fault. In fault, `refEn` is 1, `faultLatched` is 1, the gates are high and every other output is 0.
- R4: `protGateN` goes low in the cycle after the second peak.
- R5: `overTemp` high during the second up/down ramp pair causes a fault, so the boost never starts. `overTemp` is ignored in every other phase.
- R6: `boostSs` rises at the start of the third up-ramp.
- R7: `negEn` rises in the cycle after the fourth peak.
- R8: `delBoostN` goes low in the cycle after the fifth peak.
- R9: `posEn` rises at the start of the sixth up-ramp.
- R10: At the sixth peak, `railsOk` high sets `seqDone` and keeps every rail on. `railsOk` low enters fault.
- R11: If a ramp phase has not ended after WDOG_LIM cycles (the end condition of R2 not met), the block enters fault.
- R12: A fault persists while `enable` and `supplyOk` stay high. `enable` low returns the block to the idle outputs. `supplyOk` low returns it to the all-off outputs.
- R13: `enable` low while sequencing, or after completion, returns the block to the idle outputs: `refEn` and `logicEn` high, gates high, other rails off. The next run restarts from the first ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyOk | input | 1 | Input supply above its good threshold |
| enable | input | 1 | Enable pin, high to run the sequence |
| refOk | input | 1 | Reference within tolerance |
| overTemp | input | 1 | Die temperature out of range |
| rampHi | input | 1 | Timing node at or above the upper threshold |
| rampLo | input | 1 | Timing node at or below the lower threshold |
| railsOk | input | 1 | All sequenced rails in regulation |
| refEn | output | 1 | Reference enable |
| logicEn | output | 1 | Logic rail enable |
| protGateN | output | 1 | Input protection switch gate, active low |
| boostSs | output | 1 | Boost soft-start enable |
| negEn | output | 1 | Negative rail enable |
| delBoostN | output | 1 | Delayed boost output gate, active low |
| posEn | output | 1 | Positive gate rail enable |
| seqDone | output | 1 | Sequence completed cleanly |
| faultLatched | output | 1 | Fault latched |

## Verification
The hardest states to reach are a stuck timing node and a ramp whose peak is late. Both depend on how the comparator inputs behave over dozens of cycles, not on a single event. The bench holds `rampHi` or `rampLo` at zero from the start of a run, so the phase watchdog expires in a known cycle. It also releases `rampHi` a few cycles after the minimum up-ramp length, so that every later event shifts by the same amount. Temperature is raised inside and outside its qualification window, which shows that only the second ramp pair reacts to it.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int NUM_PEAKS  = 6;
  localparam int NUM_PHASES = 2 * NUM_PEAKS - 1;
  localparam int PHASE_W    = $clog2(NUM_PHASES + 1);

  typedef logic [PHASE_W-1:0] phase_t;

  // Phase indices: even = up-ramp, odd = down-ramp. An event keyed to a
  // phase fires at the end of that phase.
  localparam phase_t PH_TEST_END   = phase_t'(3);  // last self-test phase
  localparam phase_t PH_TEMP_FIRST = phase_t'(2);  // second ramp pair begins
  localparam phase_t PH_PROT       = phase_t'(2);  // second peak
  localparam phase_t PH_BOOST      = phase_t'(3);  // into third up-ramp
  localparam phase_t PH_NEG        = phase_t'(6);  // fourth peak
  localparam phase_t PH_DEL        = phase_t'(8);  // fifth peak
  localparam phase_t PH_POS        = phase_t'(9);  // into sixth up-ramp
  localparam phase_t PH_LAST       = phase_t'(NUM_PHASES - 1); // sixth peak

  typedef enum logic [2:0] {
    SQ_OFF, SQ_IDLE, SQ_RUN, SQ_DONE, SQ_FAULT
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic run;
  } rampCmd_t;
endpackage

// File: rtl/rail_seq_ramp.sv
module rail_seq_ramp
  import rail_seq_pkg::*;
#(
  parameter int FAST_CYC = 16,
  parameter int SLOW_CYC = 48,
  parameter int DOWN_CYC = 32,
  parameter int WDOG_LIM = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  rampCmd_t cmd,
  input  logic     rampHi,
  input  logic     rampLo,
  output phase_t   phaseIdx,
  output logic     phaseEnd,
  output logic     stuck
);
  localparam int UP_LEN = FAST_CYC + SLOW_CYC;
  localparam int CNT_W  = $clog2(WDOG_LIM + 1);
  localparam logic [CNT_W-1:0] UP_END = CNT_W'(UP_LEN - 1);
  localparam logic [CNT_W-1:0] DN_END = CNT_W'(DOWN_CYC - 1);
  localparam logic [CNT_W-1:0] WD_END = CNT_W'(WDOG_LIM - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic isUp, upDone, dnDone;

  always_comb begin
    isUp     = ~phaseIdx[0];
    upDone   = isUp  && (phaseCnt >= UP_END) && rampHi;
    dnDone   = !isUp && (phaseCnt >= DN_END) && rampLo;
    phaseEnd = cmd.run && (upDone || dnDone);
    stuck    = cmd.run && !(upDone || dnDone) && (phaseCnt == WD_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      phaseIdx <= '0;
    end else if (cmd.clr) begin
      phaseCnt <= '0;
      phaseIdx <= '0;
    end else if (cmd.run) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        phaseIdx <= phaseIdx + phase_t'(1);
      end else if (phaseCnt != WD_END) begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.run && !phaseEnd |=> $stable(phaseIdx)); // R2
  AST_END_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rstN)
    phaseEnd |-> (rampHi || rampLo)); // R2
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     supplyOk,
  input  logic     enable,
  input  logic     refOk,
  input  logic     overTemp,
  input  logic     railsOk,
  input  phase_t   phaseIdx,
  input  logic     phaseEnd,
  input  logic     stuck,
  output rampCmd_t cmd,
  output logic     refEn,
  output logic     logicEn,
  output logic     protGateN,
  output logic     boostSs,
  output logic     negEn,
  output logic     delBoostN,
  output logic     posEn,
  output logic     seqDone,
  output logic     faultLatched
);
  seqState_t state, stateNx;
  logic protOn, boostOn, negOn, delOn, posOn;
  logic inTest, inTemp, faultHit;

  always_comb begin
    inTest   = (phaseIdx <= PH_TEST_END);
    inTemp   = (phaseIdx >= PH_TEMP_FIRST) && inTest;
    faultHit = (inTest && !refOk) || (inTemp && overTemp) || stuck;
    stateNx  = state;
    unique case (state)
      SQ_OFF:   if (supplyOk) stateNx = SQ_IDLE;
      SQ_IDLE:  if (enable) stateNx = SQ_RUN;
      SQ_RUN: begin
        if (!enable)       stateNx = SQ_IDLE;
        else if (faultHit) stateNx = SQ_FAULT;
        else if (phaseEnd && phaseIdx == PH_LAST)
          stateNx = railsOk ? SQ_DONE : SQ_FAULT;
      end
      SQ_DONE:  if (!enable) stateNx = SQ_IDLE;
      SQ_FAULT: if (!enable) stateNx = SQ_IDLE;
      default:  stateNx = SQ_OFF;
    endcase
    if (!supplyOk) stateNx = SQ_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SQ_OFF;
    else       state <= stateNx;
  end

  // Rail event flags: set at the end of their phase, cleared whenever the
  // block leaves the running/done states.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {protOn, boostOn, negOn, delOn, posOn} <= '0;
    end else if (stateNx != SQ_RUN && stateNx != SQ_DONE) begin
      {protOn, boostOn, negOn, delOn, posOn} <= '0;
    end else if (state == SQ_RUN && phaseEnd) begin
      if (phaseIdx == PH_PROT)  protOn  <= 1'b1;
      if (phaseIdx == PH_BOOST) boostOn <= 1'b1;
      if (phaseIdx == PH_NEG)   negOn   <= 1'b1;
      if (phaseIdx == PH_DEL)   delOn   <= 1'b1;
      if (phaseIdx == PH_POS)   posOn   <= 1'b1;
    end
  end

  always_comb begin
    cmd.run      = (state == SQ_RUN);
    cmd.clr      = (state != SQ_RUN);
    refEn        = (state != SQ_OFF);
    logicEn      = (state == SQ_IDLE) || (state == SQ_RUN) || (state == SQ_DONE);
    protGateN    = !protOn;
    boostSs      = boostOn;
    negEn        = negOn;
    delBoostN    = !delOn;
    posEn        = posOn;
    seqDone      = (state == SQ_DONE);
    faultLatched = (state == SQ_FAULT);
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_FAULT) && enable && supplyOk |=> (state == SQ_FAULT)); // R12
  AST_BOOST_AFTER_PROT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boostOn) |-> protOn); // R6
  AST_BOOST_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boostOn) |-> $past(!overTemp && refOk)); // R5
  AST_POS_LAST_RAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(posOn) |-> (boostOn && negOn && delOn)); // R9
  AST_DONE_AT_LAST_PEAK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> ($past(phaseIdx) == PH_LAST) && $past(railsOk)); // R10
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int FAST_CYC = 16,
  parameter int SLOW_CYC = 48,
  parameter int DOWN_CYC = 32,
  parameter int WDOG_LIM = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic enable,
  input  logic refOk,
  input  logic overTemp,
  input  logic rampHi,
  input  logic rampLo,
  input  logic railsOk,
  output logic refEn,
  output logic logicEn,
  output logic protGateN,
  output logic boostSs,
  output logic negEn,
  output logic delBoostN,
  output logic posEn,
  output logic seqDone,
  output logic faultLatched
);
  rampCmd_t cmd;
  phase_t   phaseIdx;
  logic     phaseEnd, stuck;

  rail_seq_ramp #(
    .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC),
    .DOWN_CYC(DOWN_CYC), .WDOG_LIM(WDOG_LIM)
  ) u_ramp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rampHi(rampHi), .rampLo(rampLo),
    .phaseIdx(phaseIdx), .phaseEnd(phaseEnd), .stuck(stuck)
  );

  rail_seq_fsm u_fsm (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enable(enable),
    .refOk(refOk), .overTemp(overTemp), .railsOk(railsOk),
    .phaseIdx(phaseIdx), .phaseEnd(phaseEnd), .stuck(stuck), .cmd(cmd),
    .refEn(refEn), .logicEn(logicEn), .protGateN(protGateN),
    .boostSs(boostSs), .negEn(negEn), .delBoostN(delBoostN), .posEn(posEn),
    .seqDone(seqDone), .faultLatched(faultLatched)
  );
endmodule

// File: tb/rail_seq_ctrl_bench.sv
module rail_seq_ctrl_bench;
  // Up-ramp 8 cycles, down-ramp 4 cycles, watchdog 20 cycles.
  localparam int FAST = 3, SLOW = 5, DOWN = 4, WDOG = 20;

  // Output order: ref, logic, protN, boost, neg, delN, pos, done, fault
  localparam logic [8:0] O_OFF   = 9'b001001000;
  localparam logic [8:0] O_IDLE  = 9'b111001000;
  localparam logic [8:0] O_FAULT = 9'b101001001;
  localparam logic [8:0] O_DONE  = 9'b110110110;

  typedef struct packed {
    logic [31:0] k;
    logic [8:0]  e;
    logic [31:0] tag;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'd0,  9'b111001000, "R2"},
    '{32'd19, 9'b111001000, "R4"},
    '{32'd20, 9'b110001000, "R4"},
    '{32'd23, 9'b110001000, "R6"},
    '{32'd24, 9'b110101000, "R6"},
    '{32'd43, 9'b110101000, "R7"},
    '{32'd44, 9'b110111000, "R7"},
    '{32'd55, 9'b110111000, "R8"},
    '{32'd56, 9'b110110000, "R8"},
    '{32'd59, 9'b110110000, "R9"},
    '{32'd60, 9'b110110100, "R9"},
    '{32'd67, 9'b110110100, "R10"},
    '{32'd68, 9'b110110110, "R10"}
  };

  logic clk = 1'b0;
  logic rstN, supplyOk, enable, refOk, overTemp, rampHi, rampLo, railsOk;
  logic refEn, logicEn, protGateN, boostSs, negEn, delBoostN, posEn, seqDone, faultLatched;
  logic [8:0] obs;
  int checks = 0, fails = 0, k = 0;

  always #2 clk = ~clk;

  rail_seq_ctrl #(.FAST_CYC(FAST), .SLOW_CYC(SLOW), .DOWN_CYC(DOWN), .WDOG_LIM(WDOG)) u_rail_seq_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enable(enable), .refOk(refOk),
    .overTemp(overTemp), .rampHi(rampHi), .rampLo(rampLo), .railsOk(railsOk),
    .refEn(refEn), .logicEn(logicEn), .protGateN(protGateN), .boostSs(boostSs),
    .negEn(negEn), .delBoostN(delBoostN), .posEn(posEn), .seqDone(seqDone),
    .faultLatched(faultLatched)
  );

  assign obs = {refEn, logicEn, protGateN, boostSs, negEn, delBoostN, posEn, seqDone, faultLatched};

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, obs, exp);
    end
  endtask

  task automatic startRun();
    @(negedge clk); enable = 1'b1;
    @(posedge clk); k = 0;
  endtask

  task automatic waitK(input int t);
    while (k < t) begin @(posedge clk); k++; end
    @(negedge clk);
  endtask

  task automatic goIdle();
    @(negedge clk); enable = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 0; supplyOk = 0; enable = 0; refOk = 1; overTemp = 0;
    rampHi = 1; rampLo = 1; railsOk = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R1 reset", O_OFF);
    rstN = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); check("R1 supply low", O_OFF);
    supplyOk = 1;
    @(posedge clk); @(negedge clk); check("R1 supply good, enable low", O_IDLE);
    repeat (40) @(posedge clk);
    @(negedge clk); check("R2 held while enable low", O_IDLE);

    // Nominal sequence, table driven
    startRun();
    for (int i = 0; i < NV; i++) begin
      waitK(int'(VEC[i].k));
      check($sformatf("%s seq k=%0d", VEC[i].tag, VEC[i].k), VEC[i].e);
    end
    goIdle(); check("R13 disable after done", O_IDLE);

    // R13: abort mid-run, restart from first ramp
    startRun(); waitK(10);
    enable = 1'b0; @(posedge clk); @(negedge clk);
    check("R13 abort", O_IDLE);
    startRun(); waitK(19); check("R13 restart k19", 9'b111001000);
    waitK(20); check("R13 restart k20", 9'b110001000);
    goIdle();

    // R3 reference failure in self-test, R12 latch
    startRun(); waitK(10); refOk = 1'b0;
    waitK(11); check("R3 ref fault", O_FAULT);
    refOk = 1'b1; waitK(50); check("R12 fault latched", O_FAULT);
    goIdle(); check("R12 enable low clears", O_IDLE);

    // R5 temperature during second ramp pair
    startRun(); waitK(14); overTemp = 1'b1;
    waitK(15); check("R5 temp fault", O_FAULT);
    overTemp = 1'b0; goIdle();

    // R5 temperature outside window ignored
    overTemp = 1'b1;
    startRun(); waitK(5); check("R5 early temp ignored", O_IDLE);
    overTemp = 1'b0; waitK(30); overTemp = 1'b1;
    waitK(68); check("R5 late temp ignored", O_DONE);
    overTemp = 1'b0; goIdle();

    // R10 rails not good at final peak
    railsOk = 1'b0;
    startRun(); waitK(67); check("R10 before check", 9'b110110100);
    waitK(68); check("R10 rails bad", O_FAULT);
    railsOk = 1'b1; goIdle();

    // R2 late upper comparator delays every later event by 3 cycles
    rampHi = 1'b0;
    startRun(); waitK(10); rampHi = 1'b1;
    waitK(22); check("R2 late peak k22", 9'b111001000);
    waitK(23); check("R2 late peak k23", 9'b110001000);
    goIdle();

    // R11 node stuck low: first up-ramp never peaks
    rampHi = 1'b0;
    startRun(); waitK(19); check("R11 stuck low k19", O_IDLE);
    waitK(20); check("R11 stuck low k20", O_FAULT);
    rampHi = 1'b1; goIdle();

    // R11 node stuck high: first down-ramp never ends
    rampLo = 1'b0;
    startRun(); waitK(27); check("R11 stuck high k27", O_IDLE);
    waitK(28); check("R11 stuck high k28", O_FAULT);
    rampLo = 1'b1;

    // R12 supply loss clears fault
    supplyOk = 1'b0; @(posedge clk); @(negedge clk);
    check("R12 supply loss", O_OFF);
    supplyOk = 1'b1; @(posedge clk); @(negedge clk);
    check("R1 supply return", O_IDLE);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule